// File: doc/BRIEF.md
# Reset Domain Controller

This block turns one active-low board reset pin and three software-writable control locations into the reset signals of a chip with two nested reset domains. The outer domain, the device-wide reset, is held while the pin is low or while a sticky software bit is set. The inner domain, the serial interface, has its own sticky software bit. The inner domain is also reset whenever the outer one is. A third location produces a one-cycle strobe that clears the queue pointers. No software clear is needed for it.

The pin is synchronized inside the block. It asserts at once and is released on the second rising clock edge after it goes high. Only the pin places the processor bus outputs in high impedance. A software device reset leaves the bus driven, so software can still write the bit back to 0. Each software bit keeps its own value while the reset it drives is active, so software can read it back and clear it. A programmable completion timer reports when the reset sequence has settled. Either reset held for a long time also serves as a low-power state for its domain, and this is flagged on a two-bit output.

Top module: `rst_domain_ctrl`

## Requirements
- R1: `glb_rst` is 1 whenever the synchronized pin is in reset or the device software bit is 1, and 0 otherwise.
- R2: The device software bit (location 0, data bit 0) becomes 1 one edge after a write of 1. It stays 1 until a write of 0 or a clock edge with the synchronized pin in reset. A write made while the pin is in reset is lost.
- R3: Only data bit 0 of a write sets or clears a software bit. The other data bits, and writes to locations other than 0, 1 and 2, have no effect on any output.
- R4: `bus_hiz` is 1 only while the synchronized pin is in reset. A software device reset does not raise it.
- R5: The serial software bit (location 1, data bit 0) follows the same sticky rule. It is cleared at any edge where `glb_rst` is 1, and a write to it at such an edge is lost.
- R6: `ser_rst` is 1 when `glb_rst` is 1 or the serial software bit is 1. `low_pwr[0]` equals `glb_rst` and `low_pwr[1]` equals `ser_rst`.
- R7: A write to location 2 with any data drives `qptr_rst` high for exactly the one cycle after the write edge. Back-to-back writes give back-to-back pulses. `qptr_rst` stays 0 while the synchronized pin is in reset.
- R8: `rst_done` is 0 while `ser_rst` is 1. It rises on the DONE_CYCLES-th rising edge at which `ser_rst` is sampled 0 after the sources were released, and it then stays 1 until a source becomes active again.
- R9: A low pin puts `bus_hiz` and `glb_rst` to 1 without waiting for a clock. After the pin goes high they stay 1 until the second rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| ext_rst_n | input | 1 | Board reset pin, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write location: 0 device bit, 1 serial bit, 2 queue-pointer strobe |
| wr_data | input | DATA_W | Write data; bit 0 is the control bit |
| glb_rst | output | 1 | Device-wide reset, active high |
| ser_rst | output | 1 | Serial-interface domain reset, active high |
| qptr_rst | output | 1 | One-cycle queue-pointer reset strobe |
| low_pwr | output | 2 | Low-power flags: bit 0 device, bit 1 serial domain |
| bus_hiz | output | 1 | Processor bus outputs to high impedance |
| rst_done | output | 1 | Reset sequence complete |

## Verification
A device software bit in the wrong state shows up on `glb_rst`, `ser_rst` and both `low_pwr` bits in the cycle after the write edge. A serial bit left set after a device reset shows up on `ser_rst` as soon as the device reset releases. A synchronizer that releases too early or too late moves the falling edge of `bus_hiz` by a cycle. A completion counter that is off by one moves the rise of `rst_done` by one cycle, and one that is not cleared by a source shows `rst_done` still high during a reset. The bench compares every output against its own model after each edge, so each of these faults is reported in the cycle it appears.

// File: rtl/rst_ctrl_pkg.sv
// Package: shared domain indices for the reset domain controller.
// Assumes: exactly two software-controlled reset domains, device then serial.
package rst_ctrl_pkg;
    typedef enum int unsigned {
        DOM_DEV = 0,
        DOM_SER = 1
    } rst_dom_e;

    localparam int unsigned NUM_DOM = 2;
endpackage

// File: rtl/rst_pin_sync.sv
// Module: rst_pin_sync
// Synchronizes the board reset pin. Assertion is asynchronous and release
// is synchronous after STAGES rising edges.
// Assumes: the only flops in the block reset asynchronously; all others use
// the synchronous active-low output of this module.
module rst_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic rst_n
);
    logic [STAGES-1:0] stage_q;

    // Shift ones in while the pin is high; clear immediately when it drops.
    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) stage_q <= '0;
        else        stage_q <= {stage_q[STAGES-2:0], 1'b1};
    end

    assign rst_n = stage_q[STAGES-1];
endmodule

// File: rtl/rst_sticky_bit.sv
// Module: rst_sticky_bit
// One software reset bit: it keeps its value until a write changes it or a
// clear arrives. A clear outranks a write in the same cycle.
// Assumes: clr is synchronous to clk.
module rst_sticky_bit (
    input  logic clk,
    input  logic clr,
    input  logic wr,
    input  logic din,
    output logic q
);
    // Hold, load on write, or clear when the enclosing reset is active.
    always_ff @(posedge clk) begin
        if (clr)     q <= 1'b0;
        else if (wr) q <= din;
    end
endmodule

// File: rtl/rst_done_timer.sv
// Module: rst_done_timer
// Counts LIMIT quiet cycles after every reset source has been released, then
// raises done. Any active source restarts the count.
// Assumes: LIMIT >= 1; rst_n is the synchronous active-low block reset.
module rst_done_timer #(
    parameter int unsigned LIMIT = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic done
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Restart on reset or busy; otherwise count until done latches.
    always_ff @(posedge clk) begin
        if (!rst_n || busy) begin
            cnt_q <= '0;
            done  <= 1'b0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
            done  <= (cnt_q == LAST);
        end
    end
endmodule

// File: rtl/rst_domain_ctrl.sv
// Module: rst_domain_ctrl (top)
// Builds the device and serial-domain resets from the board pin and sticky
// software bits, drives the queue-pointer strobe, the bus high-impedance
// control, low-power flags and a reset-complete flag.
// Assumes: the write port is synchronous to clk; data bit CTRL_BIT is the
// control bit; DONE_CYCLES is the completion wait in clk cycles.
module rst_domain_ctrl
    import rst_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CTRL_BIT    = 0,
    parameter int unsigned ADDR_DEV    = 0,
    parameter int unsigned ADDR_SER    = 1,
    parameter int unsigned ADDR_QPR    = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DONE_CYCLES = 250000
) (
    input  logic              clk,
    input  logic              ext_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              glb_rst,
    output logic              ser_rst,
    output logic              qptr_rst,
    output logic [1:0]        low_pwr,
    output logic              bus_hiz,
    output logic              rst_done
);
    localparam logic [ADDR_W-1:0] A_DEV = ADDR_W'(ADDR_DEV);
    localparam logic [ADDR_W-1:0] A_SER = ADDR_W'(ADDR_SER);
    localparam logic [ADDR_W-1:0] A_QPR = ADDR_W'(ADDR_QPR);

    logic               pin_rst_n;
    logic [NUM_DOM-1:0] sw_q;
    logic [NUM_DOM-1:0] dom_wr;
    logic [NUM_DOM-1:0] dom_clr;
    logic               qpr_q;

    rst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .pin_n (ext_rst_n),
        .rst_n (pin_rst_n)
    );

    // Decode the write location per domain and pick each domain's clear source.
    always_comb begin
        dom_wr[DOM_DEV]  = wr_en && (wr_addr == A_DEV);
        dom_wr[DOM_SER]  = wr_en && (wr_addr == A_SER);
        dom_clr[DOM_DEV] = !pin_rst_n;
        dom_clr[DOM_SER] = glb_rst;
    end

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        rst_sticky_bit u_bit (
            .clk (clk),
            .clr (dom_clr[d]),
            .wr  (dom_wr[d]),
            .din (wr_data[CTRL_BIT]),
            .q   (sw_q[d])
        );
    end

    // Queue-pointer strobe: one cycle after each write to its location.
    always_ff @(posedge clk) begin
        if (!pin_rst_n) qpr_q <= 1'b0;
        else            qpr_q <= wr_en && (wr_addr == A_QPR);
    end

    // Combine sources into the nested domain resets and status outputs.
    always_comb begin
        glb_rst  = !pin_rst_n || sw_q[DOM_DEV];
        ser_rst  = glb_rst || sw_q[DOM_SER];
        bus_hiz  = !pin_rst_n;
        low_pwr  = {ser_rst, glb_rst};
        qptr_rst = qpr_q;
    end

    rst_done_timer #(.LIMIT(DONE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (pin_rst_n),
        .busy  (ser_rst),
        .done  (rst_done)
    );
endmodule

// File: rtl/rst_domain_ctrl_chk.sv
// Module: rst_domain_ctrl_chk
// Property checker bound to rst_domain_ctrl; observes ports and the two
// software bits.
// Assumes: address parameters match those of the bound instance.
module rst_domain_ctrl_chk #(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned ADDR_DEV = 0,
    parameter int unsigned ADDR_QPR = 2
) (
    input logic              clk,
    input logic              ext_rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              glb_rst,
    input logic              ser_rst,
    input logic              qptr_rst,
    input logic              bus_hiz,
    input logic              rst_done,
    input logic              sw_dev,
    input logic              sw_ser
);
    // R2: a set device bit holds unless it is written.
    a_r2_dev_sticky: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (sw_dev && !(wr_en && wr_addr == ADDR_W'(ADDR_DEV))) |=> sw_dev);

    // R5: the device reset clears the serial bit.
    a_r5_ser_cleared: assert property (@(posedge clk) disable iff (!ext_rst_n)
        glb_rst |=> !sw_ser);

    // R4: with the pin high for three edges, the bus is driven.
    a_r4_bus_driven: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (ext_rst_n && $past(ext_rst_n) && $past(ext_rst_n, 2)) |-> !bus_hiz);

    // R7: every strobe comes from a write to its location.
    a_r7_qptr_from_write: assert property (@(posedge clk) disable iff (!ext_rst_n)
        qptr_rst |-> $past(wr_en && wr_addr == ADDR_W'(ADDR_QPR)));

    // R8: an active serial reset clears completion.
    a_r8_done_cleared: assert property (@(posedge clk) disable iff (!ext_rst_n)
        ser_rst |=> !rst_done);
endmodule

bind rst_domain_ctrl rst_domain_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .ADDR_DEV (ADDR_DEV),
    .ADDR_QPR (ADDR_QPR)
) u_chk (
    .clk       (clk),
    .ext_rst_n (ext_rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .glb_rst   (glb_rst),
    .ser_rst   (ser_rst),
    .qptr_rst  (qptr_rst),
    .bus_hiz   (bus_hiz),
    .rst_done  (rst_done),
    .sw_dev    (sw_q[0]),
    .sw_ser    (sw_q[1])
);

// File: tb/rst_domain_ctrl_tb.sv
// Bench for rst_domain_ctrl: directed corners then seeded random traffic,
// every output compared after each edge against a bench-side model.
module rst_domain_ctrl_tb;
    localparam int unsigned N = 20;

    logic       clk = 1'b0;
    logic       ext_rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       glb_rst, ser_rst, qptr_rst, bus_hiz, rst_done;
    logic [1:0] low_pwr;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // model state
    logic [1:0] m_sync = 2'b00;
    logic       m_dev = 1'b0, m_ser = 1'b0, m_q = 1'b0, m_done = 1'b0;
    int         m_cnt = 0;

    rst_domain_ctrl #(.DONE_CYCLES(N)) u_dut (
        .clk(clk), .ext_rst_n(ext_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .glb_rst(glb_rst), .ser_rst(ser_rst),
        .qptr_rst(qptr_rst), .low_pwr(low_pwr), .bus_hiz(bus_hiz),
        .rst_done(rst_done)
    );

    always #10 clk = ~clk;

    function automatic logic exp_glb();
        return !m_sync[1] || m_dev;
    endfunction

    function automatic logic exp_ser();
        return exp_glb() || m_ser;
    endfunction

    task automatic chk1(string tag, string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s got %0b exp %0b at %0t", tag, req, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        chk1(tag, "R1 glb_rst", glb_rst, exp_glb());
        chk1(tag, "R6 ser_rst", ser_rst, exp_ser());
        chk1(tag, "R6 low_pwr0", low_pwr[0], exp_glb());
        chk1(tag, "R6 low_pwr1", low_pwr[1], exp_ser());
        chk1(tag, "R4 bus_hiz", bus_hiz, !m_sync[1]);
        chk1(tag, "R7 qptr_rst", qptr_rst, m_q);
        chk1(tag, "R8 rst_done", rst_done, m_done);
    endtask

    // model update at a rising edge from the values before it
    task automatic model_edge(logic pin, logic we, logic [3:0] a, logic [7:0] d);
        logic ok, g, s;
        ok = m_sync[1];
        g  = exp_glb();
        s  = exp_ser();
        m_sync = pin ? {m_sync[0], 1'b1} : 2'b00;
        if (!ok)                  m_dev = 1'b0;
        else if (we && a == 4'd0) m_dev = d[0];
        if (g)                    m_ser = 1'b0;
        else if (we && a == 4'd1) m_ser = d[0];
        m_q = ok && we && (a == 4'd2);
        if (!ok || s) begin
            m_cnt = 0; m_done = 1'b0;
        end else if (!m_done) begin
            m_done = (m_cnt == N - 1);
            m_cnt++;
        end
    endtask

    task automatic cyc(string tag, logic pin, logic we, logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        ext_rst_n = pin; wr_en = we; wr_addr = a; wr_data = d;
        if (!pin) begin
            m_sync = 2'b00;
            #1;
            chk1(tag, "R9 async glb_rst", glb_rst, 1'b1);
            chk1(tag, "R9 async bus_hiz", bus_hiz, 1'b1);
        end
        @(posedge clk);
        model_edge(pin, we, a, d);
        #3;
        check_all(tag);
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) cyc(tag, 1'b1, 1'b0, 4'd0, 8'h00);
    endtask

    initial begin
        logic pin;
        void'($urandom(32'h5EED));
        // R9 reset state and R2 write lost under pin reset
        cyc("R9 reset", 1'b0, 1'b0, 4'd0, 8'h00);
        cyc("R2 write in pin reset", 1'b0, 1'b1, 4'd0, 8'h01);
        cyc("R9 reset", 1'b0, 1'b0, 4'd0, 8'h00);
        // R9 release after two edges; R4 bus driven afterwards
        idle("R9 release", 3);
        idle("R8 count", N + 2);
        // R2 sticky set
        cyc("R2 set", 1'b1, 1'b1, 4'd0, 8'h01);
        idle("R2 hold", 4);
        // R5 serial write lost while device reset
        cyc("R5 lost", 1'b1, 1'b1, 4'd1, 8'h01);
        idle("R4 sw reset keeps bus", 2);
        // R3 upper bits / other location ignored
        cyc("R3 other loc", 1'b1, 1'b1, 4'd3, 8'h00);
        cyc("R3 bit0 clear", 1'b1, 1'b1, 4'd0, 8'hFE);
        idle("R8 count", 5);
        cyc("R3 other loc", 1'b1, 1'b1, 4'd7, 8'hFF);
        cyc("R3 high bits", 1'b1, 1'b1, 4'd1, 8'hFE);
        idle("R8 count", N);
        // R5 serial sticky, cleared by device reset
        cyc("R5 set", 1'b1, 1'b1, 4'd1, 8'h01);
        idle("R5 hold", 3);
        cyc("R5 dev on", 1'b1, 1'b1, 4'd0, 8'h01);
        idle("R5 cleared", 2);
        cyc("R5 dev off", 1'b1, 1'b1, 4'd0, 8'h00);
        idle("R8 count", N + 1);
        // R7 strobes, any data, back to back
        cyc("R7 strobe", 1'b1, 1'b1, 4'd2, 8'h00);
        idle("R7 single", 2);
        cyc("R7 b2b", 1'b1, 1'b1, 4'd2, 8'h5A);
        cyc("R7 b2b", 1'b1, 1'b1, 4'd2, 8'hFF);
        idle("R7 single", 2);
        // R2/R5 pin clears both bits
        cyc("R5 set", 1'b1, 1'b1, 4'd1, 8'h01);
        cyc("R2 set", 1'b1, 1'b1, 4'd0, 8'h01);
        cyc("R7 in pin reset", 1'b0, 1'b1, 4'd2, 8'h01);
        cyc("R2 pin clear", 1'b0, 1'b0, 4'd0, 8'h00);
        idle("R9 release", 3);
        idle("R8 count", N + 2);
        // random traffic
        pin = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            if (pin) pin = ($urandom % 100) != 0;
            else     pin = ($urandom % 4) == 0;
            cyc("R1 random", pin, ($urandom % 5) < 2, 4'($urandom % 4),
                8'($urandom));
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule